// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge turns each 32-bit word of an alias window into one bit of a smaller backing region. It sits between a simple request port (valid/ready, address, size, write data) and a backing memory port. Two fixed window pairs are decoded. The first pair maps alias base 0x2200_0000 onto backing base 0x2000_0000. The second maps alias base 0x4200_0000 onto backing base 0x4000_0000. Each alias window is 0x0200_0000 bytes.

A read fetches the addressed backing location and returns only the selected bit, as 0 or 1. A write changes one bit in three steps: it reads the location, sets or clears the bit, and writes the location back. The backing port stays locked for the whole sequence, so no other master can change the location in between. The bit is chosen by the alias offset, and the access size changes how it is chosen. The backing memory is little-endian and 32 bits wide, and each backing access carries byte enables that match its size.

Top module: `bitband_bridge`

## Requirements
- R1: An address is claimed only when bits [31:25] equal those of an alias base. An unclaimed request sees `req_ready_o` low and causes no backing access.
- R2: The raw backing byte address is the backing base ORed with (alias offset[24:0] >> 5). A halfword access clears bit 0 of that address, and a word access clears bits [1:0].
- R3: Size code 0 (byte): the bit index is offset[4:2]. The byte enable is one-hot on lane address[1:0], with lane k at data bits [8k+7:8k]. The bit position on the data bus is {address[1:0], offset[4:2]}.
- R4: Size code 1 (halfword): the bit index is offset[5:2]. The byte enables are 4'b0011 when address[1] is 0 and 4'b1100 when it is 1. The bus bit position is {address[1], offset[5:2]}.
- R5: Size codes 2 and 3 (word): the bit index is offset[6:2], and the byte enables are 4'b1111.
- R6: A read response carries the selected backing bit in `rsp_rdata_o[0]` with every other bit zero. A write response carries all zeros.
- R7: A write reads the location and then writes back to the same address with the same byte enables. The selected bit becomes `req_wdata_i[0]`. All other bits keep their values, and write-data bits [31:1] have no effect.
- R8: `mem_lock_o` is high through both the read and the write-back of a write sequence, and it is low during a plain read.
- R9: Only one request is in flight at a time, and `req_ready_o` is low while it runs. `rsp_valid_o` is a single-cycle pulse. It comes in the cycle after the backing acknowledge of the last access: the read for a read request, the write-back for a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (idle and address claimed) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Alias address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata_i | input | 32 | Write data, bit 0 used |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Zero-extended bit result |
| mem_req_o | output | 1 | Backing access request, held until acknowledged |
| mem_we_o | output | 1 | Backing write |
| mem_addr_o | output | 32 | Backing byte address, aligned to size |
| mem_be_o | output | 4 | Backing byte enables |
| mem_wdata_o | output | 32 | Backing write data |
| mem_lock_o | output | 1 | Backing port locked for a read-modify-write |
| mem_ready_i | input | 1 | Backing acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Backing read data |

## Verification
The request is accepted on clock edge E0. With W wait cycles on each backing access, a read response appears 2+W falling edges after E0, and a write response appears 4+2W falling edges after E0. The bench counts falling edges from acceptance and compares the count with these values, using memory latencies of zero and two. The bench samples all outputs on the falling edge. Its memory model records the address, byte enables and lock of each backing access at the falling edge where it acknowledges. The bench then compares these records and the contents of the memory with values it computes from the alias offset.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned LW   = $clog2(NB);
  localparam int unsigned IDXW = $clog2(DW);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_BACK = 2'd1,
    ST_WR_BACK = 2'd2,
    ST_RESP    = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_window_decode.sv
`timescale 1ns/1ps
module bb_window_decode #(
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned AW          = 32,
  parameter int unsigned WIN_BITS    = 25,
  parameter int unsigned SHIFT       = 5,
  parameter logic [NUM_REGIONS-1:0][AW-1:0] ALIAS_BASE = '0,
  parameter logic [NUM_REGIONS-1:0][AW-1:0] BACK_BASE  = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] back_addr_o
);
  logic [NUM_REGIONS-1:0]         match;
  logic [NUM_REGIONS-1:0][AW-1:0] cand;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign match[r] = (addr_i[AW-1:WIN_BITS] == ALIAS_BASE[r][AW-1:WIN_BITS]);
    assign cand[r]  = BACK_BASE[r] | AW'(addr_i[WIN_BITS-1:0] >> SHIFT);
  end

  // lowest-numbered matching region wins
  always_comb begin
    hit_o       = 1'b0;
    back_addr_o = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (match[r]) begin
        hit_o       = 1'b1;
        back_addr_o = cand[r];
      end
    end
  end
endmodule

// File: rtl/bb_lane_map.sv
`timescale 1ns/1ps
module bb_lane_map
  import bb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  acc_size_e       size_i,
  input  logic [AW-1:0]   raw_addr_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [AW-1:0]   addr_o,
  output logic [NB-1:0]   be_o,
  output logic [IDXW-1:0] bitpos_o
);
  logic [LW-1:0] lane;
  assign lane = raw_addr_i[LW-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        addr_o   = raw_addr_i;
        be_o     = NB'(1) << lane;
        bitpos_o = {lane, idx_i[2:0]};
      end
      SZ_HALF: begin
        addr_o   = {raw_addr_i[AW-1:1], 1'b0};
        be_o     = NB'(3) << {lane[LW-1:1], 1'b0};
        bitpos_o = {lane[LW-1:1], idx_i[3:0]};
      end
      default: begin
        addr_o   = {raw_addr_i[AW-1:LW], {LW{1'b0}}};
        be_o     = {NB{1'b1}};
        bitpos_o = idx_i;
      end
    endcase
  end
endmodule

// File: rtl/bb_rmw_fsm.sv
`timescale 1ns/1ps
module bb_rmw_fsm
  import bb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            write_i,
  input  logic            wval_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NB-1:0]   be_i,
  input  logic [IDXW-1:0] bitpos_i,
  output logic            idle_o,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [NB-1:0]   mem_be_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_lock_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  bb_state_e       st_q;
  logic            write_q, wval_q, bit_q;
  logic [AW-1:0]   addr_q;
  logic [NB-1:0]   be_q;
  logic [IDXW-1:0] bitpos_q;
  logic [DW-1:0]   word_q;
  logic [DW-1:0]   bit_mask;

  assign bit_mask = DW'(1) << bitpos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      write_q  <= 1'b0;
      wval_q   <= 1'b0;
      bit_q    <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      bitpos_q <= '0;
      word_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          write_q  <= write_i;
          wval_q   <= wval_i;
          addr_q   <= addr_i;
          be_q     <= be_i;
          bitpos_q <= bitpos_i;
          st_q     <= ST_RD_BACK;
        end
        ST_RD_BACK: if (mem_ready_i) begin
          bit_q  <= mem_rdata_i[bitpos_q];
          word_q <= wval_q ? (mem_rdata_i | bit_mask) : (mem_rdata_i & ~bit_mask);
          st_q   <= write_q ? ST_WR_BACK : ST_RESP;
        end
        ST_WR_BACK: if (mem_ready_i) st_q <= ST_RESP;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_RD_BACK) || (st_q == ST_WR_BACK);
  assign mem_we_o    = (st_q == ST_WR_BACK);
  assign mem_addr_o  = addr_q;
  assign mem_be_o    = be_q;
  assign mem_wdata_o = mem_we_o ? word_q : '0;
  assign mem_lock_o  = write_q && mem_req_o;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_rdata_o = DW'(bit_q && !write_q);
endmodule

// File: rtl/bitband_bridge.sv
`timescale 1ns/1ps
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned AW          = 32,
  parameter int unsigned WIN_BITS    = 25,
  parameter logic [NUM_REGIONS-1:0][AW-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS-1:0][AW-1:0] BACK_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  output logic          mem_lock_o,
  input  logic          mem_ready_i,
  input  logic [31:0]   mem_rdata_i
);
  localparam int unsigned SHIFT = IDXW;

  logic            hit, idle, start;
  logic [AW-1:0]   raw_addr, map_addr;
  logic [NB-1:0]   map_be;
  logic [IDXW-1:0] map_bitpos;

  bb_window_decode #(
    .NUM_REGIONS(NUM_REGIONS), .AW(AW), .WIN_BITS(WIN_BITS), .SHIFT(SHIFT),
    .ALIAS_BASE(ALIAS_BASE), .BACK_BASE(BACK_BASE)
  ) u_dec (
    .addr_i(req_addr_i), .hit_o(hit), .back_addr_o(raw_addr)
  );

  bb_lane_map #(.AW(AW)) u_lane (
    .size_i    (acc_size_e'(req_size_i)),
    .raw_addr_i(raw_addr),
    .idx_i     (req_addr_i[2 +: IDXW]),
    .addr_o    (map_addr),
    .be_o      (map_be),
    .bitpos_o  (map_bitpos)
  );

  assign req_ready_o = idle && hit;
  assign start       = req_valid_i && req_ready_o;

  bb_rmw_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i    (start),
    .write_i    (req_write_i),
    .wval_i     (req_wdata_i[0]),
    .addr_i     (map_addr),
    .be_i       (map_be),
    .bitpos_i   (map_bitpos),
    .idle_o     (idle),
    .rsp_valid_o, .rsp_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_lock_o,
    .mem_ready_i, .mem_rdata_i
  );
endmodule

// File: rtl/bitband_bridge_checker.sv
`timescale 1ns/1ps
module bitband_bridge_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_rdata_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [3:0]  mem_be_o,
  input logic        mem_lock_o,
  input logic        mem_ready_i
);
  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_busy_no_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);
  assert_rdata_zero_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rdata_o[31:1] == '0));
  assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o) && $stable(mem_we_o)));
  assert_wb_same_loc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_lock_o && mem_ready_i) |=>
      (mem_req_o && mem_we_o && mem_lock_o && $stable(mem_addr_o) && $stable(mem_be_o)));
  assert_write_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_lock_o);
  assert_be_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));
  assert_word_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o == 4'hF) |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind bitband_bridge bitband_bridge_checker u_chk (
  .clk_i, .rst_ni, .req_ready_o, .rsp_valid_o, .rsp_rdata_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_lock_o, .mem_ready_i
);

// File: tb/bitband_bridge_test.sv
`timescale 1ns/1ps
module bitband_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, rsp_valid, mem_req, mem_we, mem_lock;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0, mem_wait = 0, wcnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [3:0]  last_rd_be, last_wr_be;
  logic        last_rd_lock, last_wr_lock;
  logic [31:0] mem [0:31];
  bit          finished = 0;

  always #2.5 clk = ~clk;

  bitband_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_lock_o(mem_lock),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  function automatic int midx(logic [31:0] a);
    return {a[30], a[5:2]};
  endfunction

  // backing memory model, acts on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == mem_wait) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[midx(mem_addr)][8*k +: 8] = mem_wdata[8*k +: 8];
          wr_cnt++; last_wr_addr = mem_addr; last_wr_be = mem_be; last_wr_lock = mem_lock;
        end else begin
          mem_rdata = mem[midx(mem_addr)];
          rd_cnt++; last_rd_addr = mem_addr; last_rd_be = mem_be; last_rd_lock = mem_lock;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic logic [31:0] f_addr(logic [31:0] a, logic [1:0] sz);
    logic [31:0] b;
    b = (a[30] ? 32'h4000_0000 : 32'h2000_0000) | {7'd0, a[24:0]} >> 5;
    if (sz == 2'd1) b[0] = 1'b0;
    else if (sz[1]) b[1:0] = 2'b00;
    return b;
  endfunction
  function automatic logic [3:0] f_be(logic [31:0] a, logic [1:0] sz);
    logic [31:0] b;
    b = f_addr(a, sz);
    if (sz == 2'd0) return 4'b0001 << b[1:0];
    if (sz == 2'd1) return b[1] ? 4'b1100 : 4'b0011;
    return 4'hF;
  endfunction
  function automatic int f_bit(logic [31:0] a, logic [1:0] sz);
    logic [31:0] b;
    b = f_addr(a, sz);
    if (sz == 2'd0) return {b[1:0], a[4:2]};
    if (sz == 2'd1) return {b[1], a[5:2]};
    return a[6:2];
  endfunction

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input string req,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #1;
    chk(req_ready === 1'b1, {req, "/R1 accept"}, req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk); lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 pulse", rsp_valid, 0);
  endtask

  task automatic read_check(input logic [31:0] a, input logic [1:0] sz, input string req);
    logic [31:0] rd, w; int lat, r0;
    w = mem[midx(f_addr(a, sz))];
    r0 = rd_cnt;
    access(1'b0, a, sz, 32'h0, req, rd, lat);
    chk(rd === {31'd0, w[f_bit(a, sz)]}, {req, "/R6 data"}, rd, {31'd0, w[f_bit(a, sz)]});
    chk(last_rd_addr === f_addr(a, sz), {req, "/R2 addr"}, last_rd_addr, f_addr(a, sz));
    chk(last_rd_be === f_be(a, sz), {req, " be"}, last_rd_be, f_be(a, sz));
    chk(rd_cnt == r0 + 1 && last_rd_lock === 1'b0, "R8 read unlocked", last_rd_lock, 0);
    chk(lat == 2 + mem_wait, "R9 read latency", lat, 2 + mem_wait);
  endtask

  task automatic write_check(input logic [31:0] a, input logic [1:0] sz,
                             input logic [31:0] wd, input string req);
    logic [31:0] rd, w; int lat, r0, w0, i;
    i = midx(f_addr(a, sz));
    w = mem[i];
    w[f_bit(a, sz)] = wd[0];
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, a, sz, wd, req, rd, lat);
    chk(mem[i] === w, {req, "/R7 backing word"}, mem[i], w);
    chk(rd === 32'd0, "R6 write rsp zero", rd, 0);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R7 one read one write", wr_cnt - w0, 1);
    chk(last_wr_addr === f_addr(a, sz) && last_wr_be === f_be(a, sz),
        {req, "/R7 wb location"}, last_wr_addr, f_addr(a, sz));
    chk(last_rd_lock === 1'b1 && last_wr_lock === 1'b1, "R8 lock held",
        {last_rd_lock, last_wr_lock}, 2'b11);
    chk(lat == 4 + 2 * mem_wait, "R9 write latency", lat, 4 + 2 * mem_wait);
  endtask

  task automatic t_reset;
    #1;
    chk(rsp_valid === 1'b0 && mem_req === 1'b0 && mem_lock === 1'b0, "R9 reset idle",
        {rsp_valid, mem_req, mem_lock}, 0);
  endtask

  task automatic t_byte;
    read_check(32'h2200_0000 + 0 * 32 + 0 * 4, 2'd0, "R3 b0 lane0");
    read_check(32'h2200_0000 + 1 * 32 + 7 * 4, 2'd0, "R3 b7 lane1");
    read_check(32'h2200_0000 + 3 * 32 + 2 * 4, 2'd0, "R3 lane3");
    read_check(32'h2200_0000 + 6 * 32 + 5 * 4, 2'd0, "R3 lane2");
  endtask

  task automatic t_half;
    read_check(32'h2200_0000 + 32'h03C, 2'd1, "R4 idx15 low");
    read_check(32'h2200_0000 + 32'h05C, 2'd1, "R4 high half");
    read_check(32'h2200_0000 + 32'h0A4, 2'd1, "R4 odd raw");
  endtask

  task automatic t_word;
    read_check(32'h2200_0000 + 32'h07C, 2'd2, "R5 idx31");
    read_check(32'h2200_0000 + 32'h100, 2'd2, "R5 idx0");
    read_check(32'h2200_0000 + 32'h1E8, 2'd3, "R5 size3");
  endtask

  task automatic t_write;
    write_check(32'h2200_0000 + 32'h044, 2'd0, 32'h1, "R7 set byte");
    write_check(32'h2200_0000 + 32'h044, 2'd0, 32'h0, "R7 clear byte");
    write_check(32'h2200_0000 + 32'h0DC, 2'd1, 32'h1, "R4 set half");
    write_check(32'h2200_0000 + 32'h07C, 2'd2, 32'h0, "R5 clear word");
    read_check (32'h2200_0000 + 32'h07C, 2'd2, "R7 readback");
  endtask

  task automatic t_upper;
    write_check(32'h2200_0000 + 32'h120, 2'd2, 32'hFFFF_FFFE, "R7 upper ignored clr");
    write_check(32'h2200_0000 + 32'h124, 2'd2, 32'h0000_0001, "R7 set");
    write_check(32'h2200_0000 + 32'h124, 2'd2, 32'h8000_0000, "R7 upper ignored clr2");
  endtask

  task automatic t_region_hi;
    read_check (32'h4200_0000 + 32'h1FC, 2'd2, "R1 region1 read");
    write_check(32'h4200_0000 + 32'h2A8, 2'd0, 32'h1, "R2 region1 write");
    read_check (32'h43FF_F800 + 32'h01C, 2'd0, "R2 top of window");
  endtask

  task automatic t_miss;
    logic [31:0] addrs [3] = '{32'h2400_0000, 32'h21FF_FFFC, 32'h2000_0000};
    int r0 = rd_cnt, w0 = wr_cnt;
    foreach (addrs[k]) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = addrs[k]; req_size = 2'd2; req_wdata = 1;
      for (int c = 0; c < 4; c++) begin
        #1;
        chk(req_ready === 1'b0 && mem_req === 1'b0 && rsp_valid === 1'b0, "R1 miss ignored",
            {req_ready, mem_req, rsp_valid}, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    chk(rd_cnt == r0 && wr_cnt == w0, "R1 miss no access", rd_cnt - r0, 0);
  endtask

  task automatic t_wait;
    mem_wait = 2;
    read_check (32'h2200_0000 + 32'h150, 2'd0, "R9 wait read");
    write_check(32'h2200_0000 + 32'h150, 2'd0, 32'h1, "R9 wait write");
    mem_wait = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'h9E37_79B9 * (i + 1) ^ (32'hA5C3_0F81 >> (i % 7));
    mem[0] = 32'h8000_0001;
    mem[1] = 32'h0000_8000;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_byte();
    t_half();
    t_word();
    t_write();
    t_upper();
    t_region_hi();
    t_miss();
    t_wait();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule